// File: doc/BRIEF.md
# Dual-Reference Selector with Holdover

This block watches two incoming reference clocks and decides which state a downstream digital PLL should be in. It runs on the local oscillator clock. Each reference passes through a two-flop synchronizer and then into a fast activity monitor, which counts oscillator cycles between rising edges. A reference is alive while its edges keep arriving within a set number of oscillator cycles. That number is a parameter, and by default it equals four nominal reference periods.

An external select pin names the reference to follow. High selects the first input and low selects the second. The block reports one of three states. Free-run means no lock has happened yet since reset. Tracking means the selected reference is alive, and the block enters this state as soon as activity appears, with no qualification delay. Holdover means the selected reference was lost after a lock.

When a lock is lost, the block pulses a freeze strobe for one cycle so the PLL keeps its last frequency word. In the same cycle it raises a loss-of-signal alarm. The alarm clears in the cycle the block returns to tracking.

After reset, a start-up window of a set number of milliseconds runs, counted in oscillator cycles. During this window the first input is always used. A low level on the select pin during the window is unsupported, and the block latches an error flag for it.

Top module: `refclk_guard`

## Requirements
- R1: After reset, `lock_state` is 2'b00 (free-run), and `los_alarm`, `freeze_stb`, `startup_err` and `ref_alive` are all 0, while `startup_busy` is 1. The code 2'b11 never appears on `lock_state`.
- R2: `startup_busy` stays high for exactly WIN_MS*(OSC_HZ/1000) oscillator cycles after reset release and then stays low. While it is high, the first reference (`ref_in[0]`) is used whatever the level of `sel_first`.
- R3: `sel_first` low while `startup_busy` is high sets `startup_err`, which then stays set until reset. `sel_first` low after the window leaves `startup_err` at 0.
- R4: When the selected reference becomes active, `lock_state` becomes 2'b01 (tracking) within four oscillator cycles of its first rising edge, from free-run or holdover, with no qualification delay.
- R5: When no rising edge of the selected reference has arrived for MISS_LIMIT oscillator cycles while tracking, `lock_state` becomes 2'b10 (holdover). In that same cycle `freeze_stb` is high for exactly one cycle and `los_alarm` rises.
- R6: `los_alarm` is 0 in every cycle `lock_state` is 2'b01. It clears in the first cycle tracking is re-entered.
- R7: With no active reference since reset, `lock_state` stays 2'b00 and `los_alarm` stays 0.
- R8: After the window, `sel_first` low selects `ref_in[1]`. A switch to a reference that is alive keeps tracking with no freeze. A switch to a dead reference while tracking goes to holdover with one freeze strobe and the alarm set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 2 | Reference clocks, asynchronous; bit 0 is the first input |
| sel_first | input | 1 | Select pin; 1 follows ref_in[0], 0 follows ref_in[1] |
| ref_alive | output | 2 | Per-reference activity flags |
| lock_state | output | 2 | 00 free-run, 01 tracking, 10 holdover |
| los_alarm | output | 1 | Loss-of-signal alarm for the selected reference |
| freeze_stb | output | 1 | One-cycle command to freeze the PLL frequency word |
| startup_busy | output | 1 | Start-up window in progress |
| startup_err | output | 1 | Sticky flag: select pin seen low during the window |

## Verification
The hardest situation to reach is a change of the select pin that lands on a dead reference while the block is tracking the other one. A loss only counts when the selected flag falls. The hard case also differs from a plain reference failure, since it must still give one freeze strobe.

The stimulus reaches it in two stages. In the first stage, random phases change only which references toggle. In the second stage, they change only the select pin. Each stage is long enough for the monitors to settle, and its expected state, alarm and strobe count come from a bench model of the transition. A directed case inside the start-up window checks that a low select pin is overridden there and flagged.

// File: rtl/refguard_pkg.sv
package refguard_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'b00,
    ST_TRACK = 2'b01,
    ST_HOLD  = 2'b10
  } lock_st_e;

  localparam int unsigned NREF = 2;
endpackage

// File: rtl/refguard_sync2.sv
module refguard_sync2 #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/refguard_act_mon.sv
module refguard_act_mon #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_s,
  output logic alive
);
  localparam int unsigned CW     = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);
  localparam logic [CW-1:0] CLST = CW'(LIMIT - 1);

  logic          ref_q;
  logic          rise;
  logic [CW-1:0] gap;

  assign rise = ref_s & ~ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      gap   <= CMAX;
      alive <= 1'b0;
    end else begin
      ref_q <= ref_s;
      if (rise) begin
        gap   <= '0;
        alive <= 1'b1;
      end else begin
        if (gap != CMAX) gap <= gap + 1'b1;
        if (gap == CLST) alive <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/refguard_startup.sv
module refguard_startup #(
  parameter int unsigned WIN_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  output logic busy,
  output logic err
);
  localparam int unsigned CW     = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] CEND = CW'(WIN_CYC);

  logic [CW-1:0] elapsed;

  assign busy = (elapsed != CEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      err     <= 1'b0;
    end else begin
      if (busy) elapsed <= elapsed + 1'b1;
      if (busy && !sel_s) err <= 1'b1;
    end
  end
endmodule

// File: rtl/refguard_fsm.sv
module refguard_fsm
  import refguard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel_alive,
  output lock_st_e state,
  output logic     los,
  output logic     freeze
);
  lock_st_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FREE:  if (sel_alive)  nxt = ST_TRACK;
      ST_TRACK: if (!sel_alive) nxt = ST_HOLD;
      ST_HOLD:  if (sel_alive)  nxt = ST_TRACK;
      default:  nxt = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FREE;
      los    <= 1'b0;
      freeze <= 1'b0;
    end else begin
      state  <= nxt;
      freeze <= (state == ST_TRACK) && (nxt == ST_HOLD);
      if (nxt == ST_HOLD && state == ST_TRACK) los <= 1'b1;
      else if (nxt == ST_TRACK)                los <= 1'b0;
    end
  end
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
  import refguard_pkg::*;
#(
  parameter int unsigned OSC_HZ     = 20_000_000,
  parameter int unsigned WIN_MS     = 251,
  parameter int unsigned REF_DIV    = 8,
  parameter int unsigned MISS_LIMIT = 4 * REF_DIV
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_in,
  input  logic       sel_first,
  output logic [1:0] ref_alive,
  output logic [1:0] lock_state,
  output logic       los_alarm,
  output logic       freeze_stb,
  output logic       startup_busy,
  output logic       startup_err
);
  localparam int unsigned CYC_PER_MS = OSC_HZ / 1000;
  localparam int unsigned WIN_CYC    = CYC_PER_MS * WIN_MS;

  logic [NREF-1:0] ref_s;
  logic            sel_s;
  logic            use_second;
  logic            sel_alive;
  lock_st_e        st;

  refguard_sync2 #(
    .W       (NREF + 1),
    .RST_VAL ({1'b1, {NREF{1'b0}}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_first, ref_in}),
    .q     ({sel_s, ref_s})
  );

  for (genvar i = 0; i < NREF; i++) begin : g_mon
    refguard_act_mon #(.LIMIT(MISS_LIMIT)) u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_s (ref_s[i]),
      .alive (ref_alive[i])
    );
  end

  refguard_startup #(.WIN_CYC(WIN_CYC)) u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_s (sel_s),
    .busy  (startup_busy),
    .err   (startup_err)
  );

  assign use_second = !startup_busy && !sel_s;
  assign sel_alive  = use_second ? ref_alive[1] : ref_alive[0];

  refguard_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_alive (sel_alive),
    .state     (st),
    .los       (los_alarm),
    .freeze    (freeze_stb)
  );

  assign lock_state = st;
endmodule

// File: rtl/refclk_guard_chk.sv
module refclk_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ref_alive,
  input logic [1:0] lock_state,
  input logic       los_alarm,
  input logic       freeze_stb,
  input logic       startup_busy,
  input logic       startup_err
);
  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state != 2'b11);

  p_busy_stays_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_busy |=> !startup_busy);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    startup_err |=> startup_err);

  p_track_needs_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == 2'b01 && $past(lock_state) != 2'b01) |-> $past(|ref_alive));

  p_freeze_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_stb |=> !freeze_stb);

  p_freeze_on_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_stb |-> (lock_state == 2'b10 && $past(lock_state) == 2'b01 && los_alarm));

  p_hold_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state == 2'b10 |-> los_alarm);

  p_track_no_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state == 2'b01 |-> !los_alarm);

  p_free_no_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state == 2'b00 |-> !los_alarm);
endmodule

bind refclk_guard refclk_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ref_alive    (ref_alive),
  .lock_state   (lock_state),
  .los_alarm    (los_alarm),
  .freeze_stb   (freeze_stb),
  .startup_busy (startup_busy),
  .startup_err  (startup_err)
);

// File: tb/refclk_guard_bench.sv
module refclk_guard_bench;
  localparam int OSC_HZ  = 100_000;
  localparam int WIN_MS  = 251;
  localparam int REF_DIV = 8;
  localparam int LIM     = 4 * REF_DIV;
  localparam int WIN_CYC = (OSC_HZ / 1000) * WIN_MS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_in = 2'b00;
  logic [1:0] ref_en = 2'b00;
  logic       sel_first = 1'b1;
  logic [1:0] ref_alive, lock_state;
  logic       los_alarm, freeze_stb, startup_busy, startup_err;

  int nchk = 0, nfail = 0, cyc = 0, frz_cnt = 0;
  int rel_cyc = 0, fall_cyc = -1;
  logic busy_q = 1'b1;
  int ph [2] = '{0, 0};

  always #5 clk = ~clk;

  refclk_guard #(.OSC_HZ(OSC_HZ), .WIN_MS(WIN_MS), .REF_DIV(REF_DIV)) u_refclk_guard (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .sel_first(sel_first),
    .ref_alive(ref_alive), .lock_state(lock_state), .los_alarm(los_alarm),
    .freeze_stb(freeze_stb), .startup_busy(startup_busy), .startup_err(startup_err)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!ref_en[i]) begin
        ph[i] = 0;
        ref_in[i] <= 1'b0;
      end else if (ph[i] == REF_DIV / 2 - 1) begin
        ph[i] = 0;
        ref_in[i] <= ~ref_in[i];
      end else begin
        ph[i] = ph[i] + 1;
      end
    end
    if (rst_n && busy_q && !startup_busy && fall_cyc < 0) fall_cyc = cyc;
    busy_q = startup_busy;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && freeze_stb) frz_cnt <= frz_cnt + 1;
    if (cyc == 190_000) begin
      nfail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, 190_000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_state(input logic [1:0] st, input int maxc, output int n);
    n = 0;
    while (lock_state != st && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    fall_cyc = -1;
    rst_n = 1'b1;
    rel_cyc = cyc;
  endtask

  function automatic logic [1:0] exp_state(input logic [1:0] cur, input bit s1, input logic [1:0] en);
    bit on;
    on = s1 ? en[0] : en[1];
    if (on) return 2'b01;
    if (cur == 2'b00) return 2'b00;
    return 2'b10;
  endfunction

  task automatic check_step(input logic [1:0] prev, input logic [1:0] e, input int f0, input string req);
    chk(lock_state == e, {req, " state"}, lock_state, e);
    chk(los_alarm == (e == 2'b10), {req, " los"}, los_alarm, e == 2'b10);
    chk(frz_cnt - f0 == int'(prev == 2'b01 && e == 2'b10), {req, " freeze count"},
        frz_cnt - f0, int'(prev == 2'b01 && e == 2'b10));
  endtask

  initial begin
    int n, f0;
    logic [1:0] cur, e;
    void'($urandom(32'd20240611));

    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(lock_state == 2'b00, "R1 state", lock_state, 0);
    chk(!los_alarm && !freeze_stb, "R1 alarm/freeze", {los_alarm, freeze_stb}, 0);
    chk(!startup_err && startup_busy, "R1 err/busy", {startup_err, startup_busy}, 1);
    chk(ref_alive == 2'b00, "R1 alive", ref_alive, 0);

    // R7 no reference: stays free-run
    wait_cyc(200);
    chk(lock_state == 2'b00 && !los_alarm, "R7 free-run", {lock_state, los_alarm}, 0);

    // R4 immediate lock from free-run
    ref_en = 2'b01;
    wait_state(2'b01, 60, n);
    chk(n <= REF_DIV / 2 + 4, "R4 lock latency", n, REF_DIV / 2 + 4);

    // R2/R3 select low during window: forced to first input and flagged
    sel_first = 1'b0;
    wait_cyc(20);
    chk(startup_err == 1'b1, "R3 err in window", startup_err, 1);
    chk(lock_state == 2'b01, "R2 first input forced", lock_state, 1);
    sel_first = 1'b1;

    // R5 failure of the selected reference
    f0 = frz_cnt;
    ref_en = 2'b00;
    wait_state(2'b10, 100, n);
    chk(n >= LIM - REF_DIV && n <= LIM + 6, "R5 loss latency", n, LIM);
    chk(freeze_stb == 1'b1 && los_alarm == 1'b1, "R5 freeze+los same cycle",
        {freeze_stb, los_alarm}, 3);
    @(negedge clk);
    chk(freeze_stb == 1'b0, "R5 freeze one cycle", freeze_stb, 0);
    chk(frz_cnt - f0 == 1, "R5 freeze count", frz_cnt - f0, 1);

    // R6 relock clears alarm in first tracking cycle
    ref_en = 2'b01;
    wait_state(2'b01, 60, n);
    chk(n <= REF_DIV + 6, "R4 relock latency", n, REF_DIV + 6);
    chk(los_alarm == 1'b0, "R6 los clear on relock", los_alarm, 0);

    // R2 window length, R3 stickiness
    while (fall_cyc < 0) @(negedge clk);
    chk(fall_cyc - rel_cyc == WIN_CYC, "R2 window length", fall_cyc - rel_cyc, WIN_CYC);
    wait_cyc(5);
    chk(startup_busy == 1'b0, "R2 busy stays low", startup_busy, 0);
    chk(startup_err == 1'b1, "R3 err sticky", startup_err, 1);

    // Second run: select low after window is legal
    ref_en = 2'b00;
    do_reset();
    while (fall_cyc < 0) @(negedge clk);
    sel_first = 1'b0;
    wait_cyc(10);
    chk(startup_err == 1'b0, "R3 no err after window", startup_err, 0);

    // R8 directed: switch between live references, no freeze
    ref_en = 2'b11;
    wait_cyc(60);
    chk(lock_state == 2'b01, "R8 track second input", lock_state, 1);
    f0 = frz_cnt;
    sel_first = 1'b1;
    wait_cyc(40);
    chk(lock_state == 2'b01 && frz_cnt == f0, "R8 live switch no freeze",
        {lock_state, 2'(frz_cnt - f0)}, 4);
    cur = 2'b01;

    // R8 random phases: first references, then select
    for (int k = 0; k < 40; k++) begin
      f0 = frz_cnt;
      ref_en = 2'($urandom_range(0, 3));
      wait_cyc(90);
      e = exp_state(cur, sel_first, ref_en);
      check_step(cur, e, f0, "R8 random refs");
      cur = e;
      f0 = frz_cnt;
      sel_first = 1'($urandom_range(0, 1));
      wait_cyc(20);
      e = exp_state(cur, sel_first, ref_en);
      check_step(cur, e, f0, "R8 random select");
      cur = e;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule